// File: doc/BRIEF.md
# Streaming Hamming ECC generator

This block computes a single-error-correcting Hamming code over bytes as they cross a flash data bus. The page is cut into chunks of 256 bytes. Each chunk gets 16 line-parity bits, indexed by byte address, and 6 column-parity bits, indexed by bit position within the byte. Together these form a 3-byte code that software uses to find and flip one bad bit per chunk. A page of two chunks (512 bytes) yields 6 code bytes. The generator only produces the code; correction is done elsewhere.

A 2-bit mode value drives the block. It maps directly to a two-bit field of a control register. Software enables the generator by stepping through clear, then off, then accumulate. To fetch the code it steps through off, then read, then pulls the code bytes through the data path, then returns to off. In read mode the data path carries stored code bytes, not flash data.

The byte input is a valid/ready stream. It takes a byte whenever the mode is not read, and drops `in_ready_o` in read mode. The code output is a valid/ready stream. A byte is held steady while the consumer keeps `out_ready_i` low, and the next byte appears only after a handshake.

Top module: `hecc_gen`

## Requirements
- R1: After reset every stored code byte is 0xFF, the byte counter is at zero, and `out_valid_o` is low outside read mode.
- R2: Mode encoding on `mode_i` is fixed: 2'b11 clear, 2'b00 off, 2'b01 accumulate, 2'b10 read.
- R3: Each byte accepted in accumulate mode updates the line parity. The bit at index 2k+1 toggles with the byte's parity when address bit k of the byte within its chunk is 1. The bit at index 2k toggles when that address bit is 0.
- R4: Each accepted byte updates six column-parity bits. Bit 2m+1 is the XOR of the data bits whose index has bit m set. Bit 2m is the XOR of the data bits whose index has bit m clear.
- R5: A chunk's code is stored inverted. Byte 0 is ~line[7:0]. Byte 1 is ~line[15:8]. Byte 2 is {~col[5:0], 2'b11}.
- R6: Bytes 0 to 255 of a page feed chunk 0 and bytes 256 to 511 feed chunk 1. Bytes accepted after the page is full change no code.
- R7: In read mode the output stream gives, for chunk 0 and then chunk 1, code bytes in the order 1, 0, 2. After six handshakes `out_valid_o` stays low.
- R8: Every entry into read mode restarts the output at the first code byte of chunk 0.
- R9: In off mode, bytes are accepted but change no code. `in_ready_o` is high in every mode except read, where it is low.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` holds and the stream position does not advance.
- R11: One cycle in clear mode returns every code byte to 0xFF and the byte counter to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Mode: 11 clear, 00 off, 01 accumulate, 10 read |
| in_valid_i | input | 1 | Bus byte present |
| in_ready_o | output | 1 | Byte accepted (low in read mode) |
| in_data_i | input | 8 | Bus byte |
| out_valid_o | output | 1 | Code byte present (read mode only) |
| out_ready_i | input | 1 | Consumer takes the code byte |
| out_data_o | output | 8 | Code byte |

## Verification
The hardest case to reach is the page boundary. The byte counter must cross from chunk 0 into chunk 1, and then run past 512 bytes, while the codes of both chunks are watched for leakage. The stimulus streams a full pseudo-random page and then extra bytes with the accumulator still enabled. It checks that all six code bytes still match a bit-level model of only the first 512 bytes. A separate sparse pattern sets one bit at a known address, which exposes any swap between even and odd parity bits.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

  localparam int BYTE_W     = 8;
  localparam int CHUNK_AW   = 8;                 // 256-byte chunk
  localparam int LINE_W     = 2 * CHUNK_AW;      // line-parity bits
  localparam int COL_W      = 6;                 // column-parity bits
  localparam int CODE_BYTES = 3;
  localparam int CODE_W     = CODE_BYTES * BYTE_W;

  typedef enum logic [1:0] {
    HM_OFF  = 2'b00,
    HM_ACC  = 2'b01,
    HM_READ = 2'b10,
    HM_CLR  = 2'b11
  } hecc_mode_e;

  // Six column parities: even index uses bits whose position has bit m = 0.
  function automatic logic [COL_W-1:0] col_parity(input logic [BYTE_W-1:0] d);
    logic [COL_W-1:0] c;
    c[0] = ^(d & 8'b0101_0101);
    c[1] = ^(d & 8'b1010_1010);
    c[2] = ^(d & 8'b0011_0011);
    c[3] = ^(d & 8'b1100_1100);
    c[4] = ^(d & 8'b0000_1111);
    c[5] = ^(d & 8'b1111_0000);
    return c;
  endfunction

endpackage

// File: rtl/hecc_chunk_acc.sv
module hecc_chunk_acc
  import hecc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                upd_i,
  input  logic [CHUNK_AW-1:0] addr_i,
  input  logic [BYTE_W-1:0]   data_i,
  output logic [LINE_W-1:0]   line_o,
  output logic [COL_W-1:0]    col_o
);

  logic              byte_par;
  logic [LINE_W-1:0] line_flip;

  assign byte_par = ^data_i;

  generate
    for (genvar k = 0; k < CHUNK_AW; k++) begin : g_line
      assign line_flip[2*k]   = byte_par & ~addr_i[k];
      assign line_flip[2*k+1] = byte_par &  addr_i[k];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      line_o <= '0;
      col_o  <= '0;
    end else if (upd_i) begin
      line_o <= line_o ^ line_flip;
      col_o  <= col_o ^ col_parity(data_i);
    end
  end

endmodule

// File: rtl/hecc_code_pack.sv
module hecc_code_pack
  import hecc_pkg::*;
(
  input  logic [LINE_W-1:0] line_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [CODE_W-1:0] code_o
);

  // {byte2, byte1, byte0}, inverted, two spare bits forced to one
  assign code_o = {~col_i, 2'b11, ~line_i[15:8], ~line_i[7:0]};

endmodule

// File: rtl/hecc_readout.sv
module hecc_readout
  import hecc_pkg::*;
#(
  parameter int NCHUNK = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_mode_i,
  input  logic [NCHUNK*CODE_W-1:0] codes_i,
  input  logic                     out_ready_i,
  output logic                     out_valid_o,
  output logic [BYTE_W-1:0]        out_data_o
);

  localparam int GRP_W = $clog2(NCHUNK + 1);

  logic [GRP_W-1:0] grp_q;
  logic [1:0]       sub_q;
  logic             fire;

  assign out_valid_o = rd_mode_i && (grp_q < GRP_W'(NCHUNK));
  assign fire        = out_valid_o && out_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n || !rd_mode_i) begin
      grp_q <= '0;
      sub_q <= '0;
    end else if (fire) begin
      if (sub_q == 2'd2) begin
        sub_q <= '0;
        grp_q <= grp_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  // Per-chunk output order: byte 1, byte 0, byte 2
  always_comb begin
    out_data_o = '0;
    for (int c = 0; c < NCHUNK; c++) begin
      if (grp_q == GRP_W'(c)) begin
        case (sub_q)
          2'd0:    out_data_o = codes_i[c*CODE_W + BYTE_W   +: BYTE_W];
          2'd1:    out_data_o = codes_i[c*CODE_W            +: BYTE_W];
          default: out_data_o = codes_i[c*CODE_W + 2*BYTE_W +: BYTE_W];
        endcase
      end
    end
    if (!out_valid_o) out_data_o = '0;
  end

endmodule

// File: rtl/hecc_gen.sv
module hecc_gen
  import hecc_pkg::*;
#(
  parameter int NCHUNK = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [BYTE_W-1:0] out_data_o
);

  localparam int TOTAL  = NCHUNK << CHUNK_AW;
  localparam int CNT_W  = $clog2(TOTAL + 1);
  localparam int CSEL_W = CNT_W - CHUNK_AW;

  hecc_mode_e mode;
  logic [CNT_W-1:0]          byte_cnt_q;
  logic                      page_full;
  logic                      acc_fire;
  logic                      clr;
  logic [CSEL_W-1:0]         chunk_sel;
  logic [NCHUNK*CODE_W-1:0]  codes;

  assign mode       = hecc_mode_e'(mode_i);
  assign clr        = (mode == HM_CLR);
  assign in_ready_o = (mode != HM_READ);
  assign page_full  = (byte_cnt_q == CNT_W'(TOTAL));
  assign acc_fire   = in_valid_i && in_ready_o && (mode == HM_ACC) && !page_full;
  assign chunk_sel  = byte_cnt_q[CNT_W-1:CHUNK_AW];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) byte_cnt_q <= '0;
    else if (acc_fire) byte_cnt_q <= byte_cnt_q + 1'b1;
  end

  generate
    for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
      logic [LINE_W-1:0] line;
      logic [COL_W-1:0]  col;

      hecc_chunk_acc u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .upd_i  (acc_fire && (chunk_sel == CSEL_W'(g))),
        .addr_i (byte_cnt_q[CHUNK_AW-1:0]),
        .data_i (in_data_i),
        .line_o (line),
        .col_o  (col)
      );

      hecc_code_pack u_pack (
        .line_i (line),
        .col_i  (col),
        .code_o (codes[g*CODE_W +: CODE_W])
      );
    end
  endgenerate

  hecc_readout #(.NCHUNK(NCHUNK)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_mode_i   (mode == HM_READ),
    .codes_i     (codes),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o)
  );

endmodule

// File: rtl/hecc_gen_chk.sv
module hecc_gen_chk #(
  parameter int NCHUNK = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_data_o
);

  localparam int NCODE = 3 * NCHUNK;
  localparam int RC_W  = $clog2(NCODE + 1);

  logic [RC_W-1:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || mode_i != 2'b10) rd_cnt <= '0;
    else if (out_valid_o && out_ready_i) rd_cnt <= rd_cnt + 1'b1;
  end

  // R7
  valid_only_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (mode_i == 2'b10));

  // R7
  read_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10) |-> (out_valid_o == (rd_cnt < RC_W'(NCODE))));

  // R10
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> ((mode_i != 2'b10) || $stable(out_data_o)));

  // R11
  clear_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11) |=> (!out_valid_o || out_data_o == 8'hFF));

endmodule

bind hecc_gen hecc_gen_chk #(.NCHUNK(NCHUNK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o)
);

// File: tb/hecc_gen_tb.sv
module hecc_gen_tb;

  localparam logic [1:0] M_OFF = 2'b00, M_ACC = 2'b01, M_RD = 2'b10, M_CLR = 2'b11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = M_OFF;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] sent [0:511];
  int nsent = 0;
  logic [7:0] lfsr = 8'h5A;

  always #5 clk = ~clk;

  hecc_gen u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Bit-level model: line index from byte address, column index from bit position
  function automatic logic [7:0] exp_byte(input int c, input int which);
    logic [15:0] lp = '0;
    logic [5:0]  cp = '0;
    for (int i = 0; i < 256; i++) begin
      if (c*256 + i < nsent) begin
        for (int j = 0; j < 8; j++) begin
          if (sent[c*256+i][j]) begin
            for (int k = 0; k < 8; k++) lp[2*k + ((i >> k) & 1)] ^= 1'b1;
            for (int m = 0; m < 3; m++) cp[2*m + ((j >> m) & 1)] ^= 1'b1;
          end
        end
      end
    end
    if (which == 0) return ~lp[7:0];
    if (which == 1) return ~lp[15:8];
    return {~cp, 2'b11};
  endfunction

  function automatic logic [7:0] exp_seq(input int idx);
    int ord [3] = '{1, 0, 2};
    return exp_byte(idx / 3, ord[idx % 3]);
  endfunction

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
    in_valid = 1'b0;
  endtask

  task automatic enable_acc();
    set_mode(M_CLR); nsent = 0;
    set_mode(M_OFF);
    set_mode(M_ACC);
  endtask

  task automatic send(input int n, input bit rec, input bit zeros, input int hot_addr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      in_valid = 1'b1;
      in_data  = zeros ? ((i == hot_addr) ? 8'h10 : 8'h00) : lfsr;
      if (rec && nsent < 512) begin
        sent[nsent] = in_data;
        nsent++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic read_all(input string req);
    @(negedge clk);
    mode = M_RD;
    out_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      #1;
      check(out_valid == 1'b1, req, out_valid, 1);
      check(out_data == exp_seq(i), req, out_data, exp_seq(i));
      @(negedge clk);
    end
    #1;
    check(out_valid == 1'b0, "R7 end of stream", out_valid, 0);
    @(negedge clk);
    mode = M_OFF;
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check(out_valid == 1'b0, "R1 valid low", out_valid, 0);
    check(in_ready == 1'b1, "R9 ready in off", in_ready, 1);
    nsent = 0;
    read_all("R1 blank codes");
  endtask

  task automatic t_single_bit();
    enable_acc();
    send(200, 1'b1, 1'b1, 8'hA5);
    read_all("R3 R4 R5 single bit");
  endtask

  task automatic t_full_page();
    enable_acc();
    send(512, 1'b1, 1'b0, 0);
    read_all("R6 R7 full page");
    set_mode(M_ACC);
    send(20, 1'b0, 1'b0, 0);
    read_all("R6 overflow ignored");
  endtask

  task automatic t_off_mode();
    enable_acc();
    send(100, 1'b1, 1'b0, 0);
    set_mode(M_OFF);
    #1;
    check(in_ready == 1'b1, "R9 ready in off", in_ready, 1);
    send(50, 1'b0, 1'b0, 0);
    read_all("R9 off ignores bytes");
  endtask

  task automatic t_restart_and_stall();
    enable_acc();
    send(300, 1'b1, 1'b0, 0);
    @(negedge clk);
    mode = M_RD;
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b0, "R9 ready low in read", in_ready, 0);
    @(negedge clk);
    @(negedge clk);
    #1;
    check(out_data == exp_seq(2), "R7 third byte", out_data, exp_seq(2));
    set_mode(M_OFF);
    @(negedge clk);
    mode = M_RD;
    out_ready = 1'b0;
    #1;
    check(out_data == exp_seq(0), "R8 restart", out_data, exp_seq(0));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      check(out_valid && out_data == exp_seq(0), "R10 stall hold", out_data, exp_seq(0));
    end
    out_ready = 1'b1;
    @(negedge clk);
    #1;
    check(out_data == exp_seq(1), "R10 advance after stall", out_data, exp_seq(1));
    set_mode(M_OFF);
    out_ready = 1'b0;
    read_all("R8 full restart");
  endtask

  task automatic t_clear();
    enable_acc();
    send(64, 1'b1, 1'b0, 0);
    set_mode(M_CLR);
    nsent = 0;
    read_all("R11 R2 clear blanks codes");
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single_bit();
    t_full_page();
    t_off_mode();
    t_restart_and_stall();
    t_clear();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule